// File: doc/BRIEF.md
# Prescaled Compare/Capture Timer

This block is a counter-based timer for a single clock domain. A wide up-counter advances once for every N+1 pulses of a selected tick source, where N comes from a 12-bit divider setting. The tick source is one of three clock-enable inputs (normal, fast, slow), or none. Three compare channels set a status flag when the count reaches their stored value. Two capture channels record the count when their external input rises.

The count can wrap in one of two ways. In restart mode, compare channel 1 sets the period: the counter stays on that value for one tick and then goes back to zero. In free-run mode, the counter passes every compare value and wraps only after its all-ones value, and that wrap sets a rollover flag.

Software uses a flat word-addressed register port with combinational reads. Word addresses are: 0 control, 1 divider, 2 status, 4–6 compare 1–3, 8–9 capture 1–2, 12 count. The divider, compare and capture registers sit in the low bits of the data word. The count is zero-extended to 32 bits.

Top module: `pct_timer`

## Requirements
- R1: After reset the control word reads 0x40 (normal source selected, disabled, restart mode). The divider, status, count and capture registers read 0. Every compare register reads all ones of the counter width.
- R2: With divider value N, the count advances by one on every (N+1)-th pulse of the selected source. Reading any register, the count included, never changes the count or the divider phase.
- R3: Control bits 7:6 choose the tick source: 0 none, 1 tick_norm_i, 2 tick_fast_i, 3 tick_slow_i. Pulses on the sources that are not selected have no effect on the count.
- R4: Control bit 0 enables counting, and while it is 0 the count holds. When a control write raises bit 0 with bit 1 also set, the count and the divider phase are cleared. With bit 1 clear, the count is kept.
- R5: In restart mode (control bit 9 = 0), the count stays on compare 1's value until the next advance, which loads 0. Compares 2 and 3 only set their flags and never reload.
- R6: In free-run mode (control bit 9 = 1), the count passes the compare values. The advance from all ones loads 0 and sets status bit 5. Restart mode never sets bit 5.
- R7: Status bits 0, 1 and 2 are set on the advance at which the count takes the value of compare 1, 2 and 3.
- R8: A rising edge on cap_i[k] copies the count into capture register k+1 and sets status bit 3+k. The copy is made three clock edges after the input rises. A falling edge has no effect.
- R9: Writing status with a 1 in a bit clears that bit, and a 0 leaves it unchanged. When a clear and a new event for the same bit fall on the same edge, the bit ends set.
- R10: Writing control with bit 15 set puts every register back to its R1 value at that edge and ignores the other bits written. Bit 15 then reads 1 for exactly one cycle and clears itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_norm_i | input | 1 | Tick source 1 (clock enable) |
| tick_fast_i | input | 1 | Tick source 2 (clock enable) |
| tick_slow_i | input | 1 | Tick source 3 (clock enable) |
| cap_i | input | N_CAP | Capture inputs, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |

## Verification
The bench narrows the counter to 10 bits, so the free-run wrap can be reached. At that width it checks that rollover is flagged only on the all-ones to zero step. A design that flagged on reaching all ones would set bit 5 one tick early.

In restart mode the bench checks that the counter stays on compare 1 for one tick and then returns to zero. It also checks that compare 3, placed beyond the period, is never reached. An off-by-one in the reload would skip or repeat a value.

Two same-edge cases are exercised: a status clear landing together with a compare hit, and a soft reset read back on its two following cycles. A design that gave the clear priority would lose the flag. A design whose soft-reset bit stuck, or failed to clear, would misread the control word.

The bench also checks divider phase and capture latency. Capture edges are timed so that a wrong synchroniser depth shows up as a capture that has not arrived yet.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 4'd1;
  localparam logic [ADDR_W-1:0] A_STS  = 4'd2;
  localparam int unsigned       A_CMP0 = 4;
  localparam int unsigned       A_CAP0 = 8;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd12;

  localparam int unsigned B_SWR   = 15;
  localparam int unsigned B_FREE  = 9;
  localparam int unsigned B_SRC   = 6;
  localparam int unsigned B_ENMOD = 1;
  localparam int unsigned B_EN    = 0;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_NORM = 2'd1,
    SRC_FAST = 2'd2,
    SRC_SLOW = 2'd3
  } src_e;
endpackage

// File: rtl/pct_prescaler.sv
module pct_prescaler #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] phase_q;
  logic             last;

  // >= so a divider lowered under the current phase reloads at once
  assign last   = (phase_q >= div_i);
  assign tick_o = run_i && last && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (clr_i) phase_q <= '0;
    else if (run_i) phase_q <= last ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/pct_counter.sv
module pct_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N_CMP = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        tick_i,
  input  logic                        free_run_i,
  input  logic [N_CMP-1:0][CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0]            cnt_o,
  output logic [N_CMP-1:0]            hit_o,
  output logic                        wrap_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             adv;

  assign adv = tick_i && !clr_i;

  always_comb begin
    if (!free_run_i && cnt_q == cmp_i[0]) cnt_nxt = '0;
    else                                  cnt_nxt = cnt_q + 1'b1;
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_hit
    assign hit_o[k] = adv && (cnt_nxt == cmp_i[k]);
  end

  assign wrap_o = adv && free_run_i && (cnt_q == ALL_ONES);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv)   cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pct_capture.sv
module pct_capture #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] val_o,
  output logic             evt_o
);
  logic [2:0] sync_q;
  logic       rise;

  assign rise  = sync_q[1] && !sync_q[2];
  assign evt_o = rise && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_o <= '0;
    else if (clr_i) val_o <= '0;
    else if (rise)  val_o <= cnt_i;
  end
endmodule

// File: rtl/pct_timer.sv
module pct_timer
  import pct_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 12,
  parameter int unsigned N_CMP = 3,
  parameter int unsigned N_CAP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_norm_i,
  input  logic              tick_fast_i,
  input  logic              tick_slow_i,
  input  logic [N_CAP-1:0]  cap_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  localparam int unsigned STS_W   = N_CMP + N_CAP + 1;
  localparam int unsigned ROV_BIT = N_CMP + N_CAP;

  logic                        swr_q, en_q, enmod_q, free_q;
  src_e                        src_q;
  logic [PRE_W-1:0]            div_q;
  logic [STS_W-1:0]            sts_q, sts_evt;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_q;
  logic [N_CAP-1:0][CNT_W-1:0] cap_val;
  logic [N_CAP-1:0]            cap_evt;
  logic [N_CMP-1:0]            cmp_hit;
  logic [CNT_W-1:0]            cnt_q;
  logic                        wrap, src_tick, cnt_tick;
  logic                        wr_ctrl, wr_sts, srst, en_start, clr;

  assign wr_ctrl  = reg_we_i && reg_addr_i == A_CTRL;
  assign wr_sts   = reg_we_i && reg_addr_i == A_STS;
  assign srst     = wr_ctrl && reg_wdata_i[B_SWR];
  assign en_start = wr_ctrl && !srst && reg_wdata_i[B_EN] && reg_wdata_i[B_ENMOD] && !en_q;
  assign clr      = srst || en_start;

  always_comb begin
    unique case (src_q)
      SRC_NORM: src_tick = tick_norm_i;
      SRC_FAST: src_tick = tick_fast_i;
      SRC_SLOW: src_tick = tick_slow_i;
      default:  src_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swr_q <= 1'b0; en_q <= 1'b0; enmod_q <= 1'b0; free_q <= 1'b0;
      src_q <= SRC_NORM; div_q <= '0;
    end else if (srst) begin
      swr_q <= 1'b1; en_q <= 1'b0; enmod_q <= 1'b0; free_q <= 1'b0;
      src_q <= SRC_NORM; div_q <= '0;
    end else begin
      swr_q <= 1'b0;
      if (wr_ctrl) begin
        en_q    <= reg_wdata_i[B_EN];
        enmod_q <= reg_wdata_i[B_ENMOD];
        free_q  <= reg_wdata_i[B_FREE];
        src_q   <= src_e'(reg_wdata_i[B_SRC +: 2]);
      end
      if (reg_we_i && reg_addr_i == A_DIV) div_q <= reg_wdata_i[PRE_W-1:0];
    end
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cmp_q[k] <= '1;
      else if (srst) cmp_q[k] <= '1;
      else if (reg_we_i && reg_addr_i == ADDR_W'(A_CMP0 + k))
        cmp_q[k] <= reg_wdata_i[CNT_W-1:0];
    end
  end

  pct_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .clr_i(clr), .run_i(en_q && src_tick),
    .div_i(div_q), .tick_o(cnt_tick)
  );

  pct_counter #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_cnt (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i(cnt_tick), .free_run_i(free_q),
    .cmp_i(cmp_q), .cnt_o(cnt_q), .hit_o(cmp_hit), .wrap_o(wrap)
  );

  for (genvar k = 0; k < N_CAP; k++) begin : g_cap
    pct_capture #(.CNT_W(CNT_W)) u_cap (
      .clk_i, .rst_ni, .clr_i(srst), .pin_i(cap_i[k]), .cnt_i(cnt_q),
      .val_o(cap_val[k]), .evt_o(cap_evt[k])
    );
  end

  // event set beats write-one clear
  assign sts_evt = {wrap, cap_evt, cmp_hit};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sts_q <= '0;
    else if (srst)   sts_q <= '0;
    else if (wr_sts) sts_q <= (sts_q & ~reg_wdata_i[STS_W-1:0]) | sts_evt;
    else             sts_q <= sts_q | sts_evt;
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[B_SWR]        = swr_q;
        reg_rdata_o[B_FREE]       = free_q;
        reg_rdata_o[B_SRC +: 2]   = src_q;
        reg_rdata_o[B_ENMOD]      = enmod_q;
        reg_rdata_o[B_EN]         = en_q;
      end
      A_DIV:   reg_rdata_o[PRE_W-1:0] = div_q;
      A_STS:   reg_rdata_o[STS_W-1:0] = sts_q;
      A_CNT:   reg_rdata_o[CNT_W-1:0] = cnt_q;
      default: ;
    endcase
    for (int k = 0; k < N_CMP; k++)
      if (reg_addr_i == ADDR_W'(A_CMP0 + k)) reg_rdata_o[CNT_W-1:0] = cmp_q[k];
    for (int k = 0; k < N_CAP; k++)
      if (reg_addr_i == ADDR_W'(A_CAP0 + k)) reg_rdata_o[CNT_W-1:0] = cap_val[k];
  end
endmodule

// File: rtl/pct_timer_chk.sv
module pct_timer_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N_CMP = 3,
  parameter int unsigned N_CAP = 2,
  parameter int unsigned STS_W = N_CMP + N_CAP + 1
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        swr_i,
  input logic                        srst_i,
  input logic                        clr_i,
  input logic                        en_i,
  input logic [CNT_W-1:0]            cnt_i,
  input logic [STS_W-1:0]            sts_i,
  input logic [N_CAP-1:0][CNT_W-1:0] cap_i
);
  localparam int unsigned ROV_BIT = N_CMP + N_CAP;

  // R2: count moves by one step or returns to zero
  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != $past(cnt_i)) |-> (cnt_i == $past(cnt_i) + 1'b1 || cnt_i == '0));

  // R4: disabled counter holds
  a_r4_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> (cnt_i == $past(cnt_i)));

  // R6: rollover flag rises only on the all-ones to zero step
  a_r6_rov_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_i[ROV_BIT]) |-> (cnt_i == '0 && $past(cnt_i) == {CNT_W{1'b1}}));

  for (genvar k = 0; k < N_CAP; k++) begin : g_cap
    // R8: a fresh capture flag comes with the count of the preceding cycle
    a_r8_cap_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sts_i[N_CMP+k]) |-> (cap_i[k] == $past(cnt_i)));
  end

  // R10: soft reset bit lasts one cycle
  a_r10_swr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swr_i && !srst_i) |=> !swr_i);

  // R10: soft reset leaves state at reset values
  a_r10_swr_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr_i |-> (cnt_i == '0 && sts_i == '0 && !en_i));
endmodule

bind pct_timer pct_timer_chk #(.CNT_W(CNT_W), .N_CMP(N_CMP), .N_CAP(N_CAP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .swr_i(swr_q), .srst_i(srst), .clr_i(clr),
  .en_i(en_q), .cnt_i(cnt_q), .sts_i(sts_q), .cap_i(cap_val)
);

// File: tb/pct_timer_tb.sv
`timescale 1ns/1ps
module pct_timer_tb_top;
  localparam int unsigned CW = 10;
  localparam logic [31:0] MAXC = (32'd1 << CW) - 1;

  logic        clk = 0, rst_n = 0;
  logic        t_norm = 0, t_fast = 0, t_slow = 0;
  logic [1:0]  cap = '0;
  logic        we = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  pct_timer #(.CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_norm_i(t_norm), .tick_fast_i(t_fast),
    .tick_slow_i(t_slow), .cap_i(cap), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a; #1;
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr %0d: got 0x%0h expected 0x%0h", tag, a, rdata, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic ticks(input int sel, input int n);
    @(negedge clk);
    t_norm = (sel == 1); t_fast = (sel == 2); t_slow = (sel == 3);
    repeat (n) @(negedge clk);
    t_norm = 0; t_fast = 0; t_slow = 0;
  endtask

  task automatic soft_reset;
    wr(4'd0, 32'h8000);
    @(negedge clk);
  endtask

  task automatic t_reset;
    expect_reg(4'd0, 32'h40, "R1 ctrl");
    expect_reg(4'd1, 32'h0, "R1 div");
    expect_reg(4'd2, 32'h0, "R1 status");
    expect_reg(4'd4, MAXC, "R1 cmp1");
    expect_reg(4'd6, MAXC, "R1 cmp3");
    expect_reg(4'd8, 32'h0, "R1 cap1");
    expect_reg(4'd12, 32'h0, "R1 count");
  endtask

  task automatic t_prescale;
    soft_reset();
    wr(4'd1, 32'd2);
    wr(4'd0, 32'h41);
    ticks(1, 9);
    expect_reg(4'd12, 32'd3, "R2 div3 nine pulses");
    ticks(1, 2);
    expect_reg(4'd12, 32'd3, "R2 partial period");
    @(negedge clk);
    expect_reg(4'd12, 32'd3, "R2 read no disturb");
    ticks(1, 1);
    expect_reg(4'd12, 32'd4, "R2 period completes");
  endtask

  task automatic t_source;
    soft_reset();
    wr(4'd0, 32'h81);
    ticks(1, 5); ticks(3, 5);
    expect_reg(4'd12, 32'd0, "R3 unselected ignored");
    ticks(2, 4);
    expect_reg(4'd12, 32'd4, "R3 fast source");
    wr(4'd0, 32'hC1);
    ticks(3, 3);
    expect_reg(4'd12, 32'd7, "R3 slow source");
    wr(4'd0, 32'h01);
    ticks(1, 3); ticks(2, 3); ticks(3, 3);
    expect_reg(4'd12, 32'd7, "R3 source off");
  endtask

  task automatic t_enable;
    soft_reset();
    ticks(1, 4);
    expect_reg(4'd12, 32'd0, "R4 disabled holds");
    wr(4'd0, 32'h41);
    ticks(1, 4);
    wr(4'd0, 32'h40);
    ticks(1, 3);
    expect_reg(4'd12, 32'd4, "R4 disable holds count");
    wr(4'd0, 32'h41);
    expect_reg(4'd12, 32'd4, "R4 enable keeps count");
    wr(4'd0, 32'h40);
    wr(4'd0, 32'h43);
    expect_reg(4'd12, 32'd0, "R4 enmod clears");
  endtask

  task automatic t_restart;
    soft_reset();
    wr(4'd4, 32'd5); wr(4'd5, 32'd3); wr(4'd6, 32'd7);
    wr(4'd0, 32'h41);
    ticks(1, 5);
    expect_reg(4'd12, 32'd5, "R5 reaches compare1");
    expect_reg(4'd2, 32'h03, "R7 compare1/2 flags");
    ticks(1, 1);
    expect_reg(4'd12, 32'd0, "R5 reload to zero");
    ticks(1, 7);
    expect_reg(4'd12, 32'd1, "R5 period 6");
    expect_reg(4'd2, 32'h03, "R5 compare3 beyond period");
  endtask

  task automatic t_freerun;
    soft_reset();
    wr(4'd4, 32'd5); wr(4'd6, 32'd7);
    wr(4'd0, 32'h241);
    ticks(1, 7);
    expect_reg(4'd12, 32'd7, "R6 passes compare1");
    expect_reg(4'd2, 32'h05, "R7 compare1/3 flags");
    ticks(1, 1016);
    expect_reg(4'd12, MAXC, "R6 reaches all ones");
    expect_reg(4'd2, 32'h07, "R6 no early rollover");
    ticks(1, 1);
    expect_reg(4'd12, 32'd0, "R6 wraps");
    expect_reg(4'd2, 32'h27, "R6 rollover flag");
    wr(4'd2, 32'h01);
    expect_reg(4'd2, 32'h26, "R9 clear one bit");
    wr(4'd4, 32'd1);
    @(negedge clk);
    we = 1; addr = 4'd2; wdata = 32'h3F; t_norm = 1;
    @(negedge clk);
    we = 0; t_norm = 0;
    expect_reg(4'd2, 32'h01, "R9 event beats clear");
    expect_reg(4'd12, 32'd1, "R9 count stepped");
  endtask

  task automatic t_capture;
    soft_reset();
    wr(4'd0, 32'h241);
    ticks(1, 6);
    @(negedge clk); cap[0] = 1;
    @(negedge clk);
    @(negedge clk);
    expect_reg(4'd2, 32'h00, "R8 not yet captured");
    @(negedge clk);
    expect_reg(4'd8, 32'd6, "R8 capture1 value");
    expect_reg(4'd2, 32'h08, "R8 capture1 flag");
    ticks(1, 3);
    cap[0] = 0;
    repeat (4) @(negedge clk);
    expect_reg(4'd8, 32'd6, "R8 falling ignored");
    cap[1] = 1;
    repeat (4) @(negedge clk);
    expect_reg(4'd9, 32'd9, "R8 capture2 value");
    expect_reg(4'd2, 32'h18, "R8 capture2 flag");
    cap[1] = 0;
  endtask

  task automatic t_swr;
    wr(4'd1, 32'd4); wr(4'd4, 32'd3);
    wr(4'd0, 32'h243);
    ticks(1, 20);
    wr(4'd0, 32'h8243);
    expect_reg(4'd0, 32'h8040, "R10 bit set one cycle");
    @(negedge clk);
    expect_reg(4'd0, 32'h40, "R10 self clear");
    expect_reg(4'd1, 32'h0, "R10 div reset");
    expect_reg(4'd4, MAXC, "R10 cmp reset");
    expect_reg(4'd2, 32'h0, "R10 status reset");
    expect_reg(4'd9, 32'h0, "R10 capture reset");
    expect_reg(4'd12, 32'h0, "R10 count reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_source();
    t_enable();
    t_restart();
    t_freerun();
    t_capture();
    t_swr();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule